// File: doc/BRIEF.md
# UDP Flood Traffic Generator

This block feeds an unending series of equal-sized UDP payloads into the transmit side of a UDP/IP packetizer. It stays silent until the Ethernet link reports up. For each packet it then presents the payload size in bytes, the target IP and MAC addresses, and the target and local port numbers. It raises a one-cycle start strobe together with the first 16-bit data word and steps through the rest of the payload as the packetizer acknowledges each word.

Each payload opens with a 32-bit packet number, so a receiving host can spot missing packets. The number goes up by one for every packet. Filler bytes follow it. The payload size and every address and port are elaboration-time parameters. The receive port of the packetizer is tied off: every incoming word is acknowledged and thrown away, so the packetizer's receive buffer never fills.

Top module: `udp_flood_gen`

## Requirements
- R1: While reset (active low, asynchronous) is asserted and on the first cycle after it, `tx_start`, `tx_valid` and `rx_ack` are 0. The first packet after reset carries packet number 0.
- R2: `tx_start` and `tx_valid` stay 0 while `link_up` is low and no packet is in progress.
- R3: `tx_len` always equals PAYLOAD_BYTES. `dst_ip` (most significant byte first, so 10.0.0.1 is 0x0A000001), `dst_mac`, `dst_port` and `src_port` always equal their parameters.
- R4: `tx_start` is high for exactly one cycle per packet. In that cycle `tx_valid` is high and the first word is on `tx_word`. The strobe is not raised again until every word of the packet has been acknowledged.
- R5: While `tx_valid` is high and `tx_ack` is low, `tx_valid` and `tx_word` hold. After an acknowledged word, the next word is on `tx_word` in the following cycle.
- R6: Each packet takes exactly ceil(PAYLOAD_BYTES/2) acknowledges. `tx_valid` is low in the cycle after the last one.
- R7: Payload byte 2i sits in `tx_word[7:0]` of word i and byte 2i+1 sits in `tx_word[15:8]`. When PAYLOAD_BYTES is odd, the upper byte of the last word is 0x00.
- R8: Payload bytes 0..3 are the packet number, most significant byte first. Each payload byte k with 4 <= k < PAYLOAD_BYTES equals k modulo 256.
- R9: The packet number goes up by one after each completed packet, modulo 2^32.
- R10: A packet that has started always runs to completion, even if `link_up` falls part way through it.
- R11: If `link_up` is high, the next packet's `tx_start` appears two cycles after the cycle in which the last word of the previous packet was acknowledged.
- R12: `rx_ack` is high exactly when `rx_valid` is high and `rx_ack` was low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up | input | 1 | Ethernet link is up |
| tx_len | output | 16 | Payload length in bytes |
| dst_ip | output | 32 | Target IP address, MSB first |
| dst_mac | output | 48 | Target MAC address |
| dst_port | output | 16 | Target UDP port |
| src_port | output | 16 | Local UDP port |
| tx_word | output | 16 | Current payload word, first byte in bits 7:0 |
| tx_valid | output | 1 | `tx_word` is valid |
| tx_start | output | 1 | One-cycle start-of-packet strobe |
| tx_ack | input | 1 | Packetizer consumed `tx_word` |
| rx_valid | input | 1 | Packetizer offers a received word |
| rx_ack | output | 1 | Received word consumed and discarded |

## Verification
The bench uses an odd payload size, so the zero pad byte in the final word is checked. A generator that counted words by floor division would drop that word and leave the packetizer waiting. The bench acknowledges in several patterns: every cycle, every other cycle, and after two-cycle stalls. A design that advanced on a stall, or re-presented a word after an acknowledge, would then show a mismatched word. The bench drops the link part way through a packet to catch a generator that abandons a promised packet. It times the gap between back-to-back packets to catch a second start strobe or a missing one. It drives `rx_valid` high continuously to catch a receive drain that acknowledges on consecutive cycles.

// File: rtl/flood_pkg.sv
`timescale 1ns/1ps
package flood_pkg;

    // Width of the per-packet sequence number carried in the payload head.
    localparam int SEQ_W  = 32;
    // Width of one transmit data word.
    localparam int WORD_W = 16;
    // Number of payload bytes taken by the sequence number.
    localparam int HEAD_BYTES = SEQ_W / 8;

    typedef enum logic [0:0] {
        FL_IDLE = 1'b0,
        FL_SEND = 1'b1
    } fl_state_e;

endpackage

// File: rtl/flood_seq_ctr.sv
`timescale 1ns/1ps
module flood_seq_ctr
    import flood_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [SEQ_W-1:0] count
);

    logic [SEQ_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (bump) begin
            count_d = count_q + SEQ_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    // R9: one step per completed packet, wrapping naturally.
    p_seq_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bump |=> (count == $past(count) + SEQ_W'(1)));

    p_seq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count));

endmodule

// File: rtl/flood_word_fmt.sv
`timescale 1ns/1ps
module flood_word_fmt
    import flood_pkg::*;
#(
    parameter int PAYLOAD_BYTES = 46,
    localparam int WORDS = (PAYLOAD_BYTES + 1) / 2,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
)(
    input  logic [IDX_W-1:0]  idx,
    input  logic [SEQ_W-1:0]  seq,
    output logic [WORD_W-1:0] word
);

    // Byte k of the payload: sequence number big-endian, then k mod 256,
    // then zero padding past the end of the payload.
    function automatic logic [7:0] pay_byte(input int k, input logic [SEQ_W-1:0] s);
        logic [7:0] b;
        if (k < HEAD_BYTES) begin
            b = s[(SEQ_W - 8 - 8*k) +: 8];
        end else if (k < PAYLOAD_BYTES) begin
            b = 8'(k);
        end else begin
            b = 8'h00;
        end
        return b;
    endfunction

    logic [7:0] lo_byte, hi_byte;

    always_comb begin
        lo_byte = pay_byte(2 * int'(idx),     seq);
        hi_byte = pay_byte(2 * int'(idx) + 1, seq);
        word    = {hi_byte, lo_byte};
    end

endmodule

// File: rtl/flood_rx_drain.sv
`timescale 1ns/1ps
module flood_rx_drain (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    output logic rx_ack
);

    logic took_d, took_q;

    always_comb begin
        rx_ack = rx_valid && !took_q;
        took_d = rx_ack;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            took_q <= 1'b0;
        end else begin
            took_q <= took_d;
        end
    end

    // R12: never acknowledge on two cycles in a row.
    p_rx_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |=> !rx_ack);

    // R12: acknowledge only an offered word.
    p_rx_offered_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> rx_valid);

endmodule

// File: rtl/udp_flood_gen.sv
`timescale 1ns/1ps
module udp_flood_gen
    import flood_pkg::*;
#(
    parameter int          PAYLOAD_BYTES = 46,
    parameter logic [31:0] DST_IP_P      = 32'h0A00_0001,
    parameter logic [47:0] DST_MAC_P     = 48'h0200_0000_0001,
    parameter logic [15:0] DST_PORT_P    = 16'd5000,
    parameter logic [15:0] SRC_PORT_P    = 16'd6000
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    output logic [15:0] tx_len,
    output logic [31:0] dst_ip,
    output logic [47:0] dst_mac,
    output logic [15:0] dst_port,
    output logic [15:0] src_port,
    output logic [15:0] tx_word,
    output logic        tx_valid,
    output logic        tx_start,
    input  logic        tx_ack,
    input  logic        rx_valid,
    output logic        rx_ack
);

    localparam int WORDS = (PAYLOAD_BYTES + 1) / 2;
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    typedef struct packed {
        fl_state_e        state;
        logic [IDX_W-1:0] idx;
        logic             start;
        logic             valid;
    } fl_regs_t;

    fl_regs_t         r_d, r_q;
    logic             pkt_done;
    logic [SEQ_W-1:0] seq_cnt;

    // Static packet descriptors.
    assign tx_len   = 16'(PAYLOAD_BYTES);
    assign dst_ip   = DST_IP_P;
    assign dst_mac  = DST_MAC_P;
    assign dst_port = DST_PORT_P;
    assign src_port = SRC_PORT_P;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        pkt_done  = 1'b0;
        unique case (r_q.state)
            FL_IDLE: begin
                r_d.valid = 1'b0;
                r_d.idx   = '0;
                if (link_up) begin
                    r_d.state = FL_SEND;
                    r_d.valid = 1'b1;
                    r_d.start = 1'b1;
                end
            end
            FL_SEND: begin
                if (tx_ack && r_q.valid) begin
                    if (r_q.idx == LAST_IDX) begin
                        pkt_done  = 1'b1;
                        r_d.state = FL_IDLE;
                        r_d.valid = 1'b0;
                        r_d.idx   = '0;
                    end else begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: FL_IDLE, idx: '0, start: 1'b0, valid: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_valid = r_q.valid;
    assign tx_start = r_q.start;

    flood_seq_ctr u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (pkt_done),
        .count (seq_cnt)
    );

    flood_word_fmt #(
        .PAYLOAD_BYTES (PAYLOAD_BYTES)
    ) u_fmt (
        .idx  (r_q.idx),
        .seq  (seq_cnt),
        .word (tx_word)
    );

    flood_rx_drain u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_ack   (rx_ack)
    );

    // R2: a strobe is only issued after the link was seen up.
    p_start_needs_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(link_up));

    // R4: strobe accompanies valid data.
    p_start_has_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> tx_valid);

    // R4: strobe is a single-cycle pulse.
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R4: no new strobe while the current packet is unfinished.
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ack) |=> !tx_start);

    // R5: an unacknowledged word is held.
    p_hold_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ack) |=> (tx_valid && $stable(tx_word)));

endmodule

// File: tb/sim_udp_flood_gen.sv
`timescale 1ns/1ps
module sim_udp_flood_gen;

    localparam int NB = 9;
    localparam int NW = (NB + 1) / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic [15:0] tx_len;
    logic [31:0] dst_ip;
    logic [47:0] dst_mac;
    logic [15:0] dst_port;
    logic [15:0] src_port;
    logic [15:0] tx_word;
    logic        tx_valid;
    logic        tx_start;
    logic        tx_ack = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_ack;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [31:0] exp_seq = 32'd0;

    always #4 clk = ~clk;

    udp_flood_gen #(
        .PAYLOAD_BYTES (NB),
        .DST_IP_P      (32'h0A00_0001),
        .DST_MAC_P     (48'h0200_0000_0001),
        .DST_PORT_P    (16'd5000),
        .SRC_PORT_P    (16'd6000)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_up  (link_up),
        .tx_len   (tx_len),
        .dst_ip   (dst_ip),
        .dst_mac  (dst_mac),
        .dst_port (dst_port),
        .src_port (src_port),
        .tx_word  (tx_word),
        .tx_valid (tx_valid),
        .tx_start (tx_start),
        .tx_ack   (tx_ack),
        .rx_valid (rx_valid),
        .rx_ack   (rx_ack)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected payload byte from R7/R8.
    function automatic logic [7:0] ebyte(input int k, input logic [31:0] s);
        if (k == 0) return s[31:24];
        if (k == 1) return s[23:16];
        if (k == 2) return s[15:8];
        if (k == 3) return s[7:0];
        if (k < NB) return 8'(k);
        return 8'h00;
    endfunction

    function automatic logic [15:0] eword(input int i, input logic [31:0] s);
        return {ebyte(2*i + 1, s), ebyte(2*i, s)};
    endfunction

    // Receives one packet; mode 0 acks each cycle, 1 every other, 2 after two stalls.
    task automatic recv_packet(input int mode, input bit drop_link);
        int wait_n = 0;
        int got = 0;
        int cyc = 0;
        bit ack_prev = 1'b0;
        logic [15:0] prev_w = '0;
        while (!tx_start && wait_n < 50) begin
            @(negedge clk);
            wait_n++;
        end
        chk(tx_start == 1'b1, "R4 strobe seen", 64'(tx_start), 64'd1);
        chk(tx_valid == 1'b1, "R4 valid with strobe", 64'(tx_valid), 64'd1);
        while (got < NW && cyc < 100) begin
            bit ack;
            if (cyc > 0) chk(tx_start == 1'b0, "R4 no second strobe", 64'(tx_start), 64'd0);
            chk(tx_valid == 1'b1, "R5 valid held", 64'(tx_valid), 64'd1);
            if (cyc > 0 && !ack_prev)
                chk(tx_word == prev_w, "R5 word held on stall", 64'(tx_word), 64'(prev_w));
            case (mode)
                0: ack = 1'b1;
                1: ack = (cyc % 2) == 1;
                default: ack = (cyc % 3) == 2;
            endcase
            if (ack) begin
                if (got < 2)
                    chk(tx_word == eword(got, exp_seq), "R8 R9 sequence word", 64'(tx_word), 64'(eword(got, exp_seq)));
                else
                    chk(tx_word == eword(got, exp_seq), "R7 R8 filler word", 64'(tx_word), 64'(eword(got, exp_seq)));
                got++;
            end
            tx_ack = ack;
            if (drop_link && got == 1) link_up = 1'b0;
            prev_w = tx_word;
            ack_prev = ack;
            @(negedge clk);
            cyc++;
        end
        tx_ack = 1'b0;
        chk(got == NW, "R6 word count", 64'(got), 64'(NW));
        chk(tx_valid == 1'b0, "R6 valid drops after last word", 64'(tx_valid), 64'd0);
        exp_seq = exp_seq + 32'd1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_start && !tx_valid && !rx_ack, "R1 outputs in reset", {tx_start, tx_valid, rx_ack}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!tx_start && !tx_valid && !rx_ack, "R1 outputs after reset", {tx_start, tx_valid, rx_ack}, 64'd0);
        chk(tx_len == 16'(NB), "R3 length", 64'(tx_len), 64'(NB));
        chk(dst_ip == 32'h0A00_0001, "R3 ip", 64'(dst_ip), 64'h0A00_0001);
        chk(dst_mac == 48'h0200_0000_0001, "R3 mac", 64'(dst_mac), 64'h0200_0000_0001);
        chk(dst_port == 16'd5000 && src_port == 16'd6000, "R3 ports", {dst_port, src_port}, {16'd5000, 16'd6000});
    endtask

    task automatic t_no_link();
        link_up = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!tx_start && !tx_valid, "R2 idle while link down", {tx_start, tx_valid}, 64'd0);
        end
    endtask

    task automatic t_single();
        link_up = 1'b1;
        recv_packet(0, 1'b0);
    endtask

    task automatic t_stall();
        recv_packet(1, 1'b0);
    endtask

    task automatic t_back_to_back();
        recv_packet(2, 1'b0);
        @(negedge clk);
        chk(tx_start == 1'b1, "R11 restart gap", 64'(tx_start), 64'd1);
        recv_packet(0, 1'b0);
    endtask

    task automatic t_link_drop();
        recv_packet(1, 1'b1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!tx_start && !tx_valid, "R10 R2 no packet after link loss", {tx_start, tx_valid}, 64'd0);
        end
    endtask

    task automatic t_rx();
        bit prev = 1'b0;
        for (int i = 0; i < 12; i++) begin
            rx_valid = (i < 8) || (i == 10);
            #1;
            chk(rx_ack == (rx_valid && !prev), "R12 drain pattern", 64'(rx_ack), 64'(rx_valid && !prev));
            prev = rx_ack;
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL R6 watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_no_link();
        t_single();
        t_stall();
        t_back_to_back();
        t_link_drop();
        t_rx();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule